// File: doc/BRIEF.md
# Character Overlay Raster Engine

This block produces the per-dot character and blanking signals for a text overlay on a television raster. It keeps a 12-row by 24-column character map. Each cell holds an 8-bit glyph code and two attribute bits: blink enable and whole-cell blanking. It follows the raster by counting dot clocks after each horizontal sync strobe and lines after each vertical sync strobe. It places the character field at a programmable origin, scales it by one, two or three on each axis, and asks an external font store for the 12-dot slice of the glyph under the beam.

Software loads the map and the control registers through a single write stream. That stream carries a valid/ready handshake. `wr_ready` is held high, so the block never applies back-pressure, and every beat with `wr_valid` high is taken on that clock edge. The font store must answer a request (`font_code`, `font_row`) with `font_bits` exactly one clock later. Bit 11 of `font_bits` is the leftmost dot. The block delays its own position state by the same clock, so each dot stays in its cell. The character output drives keying logic further down the video path. The blank output marks the area behind each glyph: the lit dots, a one-dot border on each side of them, and any cell marked for blanking.

Top module: `char_overlay_raster`

## Requirements
- R1: The map has 12 rows by 24 columns. A map write (`wr_is_reg`=0) puts the row in `wr_addr[8:5]` and the column in `wr_addr[4:0]`. In `wr_data`, bits [7:0] are the glyph code, bit 8 is blink enable and bit 9 is cell blank. A write whose row is 12 or more, or whose column is 24 or more, leaves every cell unchanged.
- R2: A register write (`wr_is_reg`=1) selects its target with `wr_addr[1:0]`. Value 0 is the horizontal start (`wr_data[5:0]`). Value 1 is the vertical start (`wr_data[5:0]`). Value 2 is the size: `wr_data[1:0]` horizontal, `wr_data[3:2]` vertical, with codes 0 = x1, 1 = x2, and 2 or 3 = x3. Value 3 is the blink rate (`wr_data[0]`: 0 = fast, 1 = slow). `wr_ready` is always 1.
- R3: Let the edge that samples `hsync` be edge 0. Display dot p of a line appears on the outputs after rising edge 4*hstart+4+p.
- R4: Count the `hsync` strobes since the last `vsync`, starting at 0. The first displayed line is the one opened by strobe number 2*vstart. Lines before it show nothing.
- R5: Each cell is 12 dots by 18 scan lines. The block presents `font_code` and `font_row` (0..17), and uses `font_bits` one clock later. Bit 11 is the leftmost dot.
- R6: At horizontal size xN, each font dot lasts N dot clocks and a line shows 288*N display dots.
- R7: At vertical size xN, each font row repeats on N consecutive lines and the field spans 216*N lines.
- R8: `chr_out` is high exactly on display dots whose glyph bit is set, unless blinking suppresses them.
- R9: `blank_out` is the OR of `chr_out` and a border. The border is high on any displayed dot whose left or right neighbouring dot is lit.
- R10: A cell with its blank bit set drives `blank_out` high over its whole 12x18 area, scaled by the size settings, whatever the glyph and blink state.
- R11: A blink phase flips after every 15 (fast) or 30 (slow) `vsync` strobes and starts in the on phase at reset. In the off phase, a blink-enabled cell shows no lit dots and no border.
- R12: After reset both outputs are low, all registers are 0 and every cell holds code 0 with both attribute bits clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | One-clock strobe that opens a scan line |
| vsync | input | 1 | One-clock strobe that opens a field |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat accepted (always 1) |
| wr_is_reg | input | 1 | 1 = control register, 0 = map cell |
| wr_addr | input | 9 | Register index or {row, column} of a cell |
| wr_data | input | 10 | Register value or {blank, blink, code} |
| font_code | output | 8 | Glyph code of the cell under the beam |
| font_row | output | 5 | Font scan row under the beam |
| font_bits | input | 12 | Dot slice returned one clock after the request |
| chr_out | output | 1 | Character dot |
| blank_out | output | 1 | Blank key: character, border or blanked cell |

## Verification
Some properties are checked on every clock. The position trackers stay inside the 12x24 grid and the 18-row font. The line-active state changes only on a sync strobe. The blink phase holds between vertical strobes. A lit dot always carries blank with it and comes from a displayed position. A blanked cell always keys the blank output. Other behaviour only shows up in the bench's scenarios, where expected values are compared dot by dot over whole lines. These include the exact dot and line where the field starts for a given origin, dot and row repetition under each size code, the border at glyph edges, alias-free rejection of out-of-range map writes, and the on and off phases at both blink rates.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int ROWS    = 12;
  localparam int COLS    = 24;
  localparam int DOTS    = 12;
  localparam int LINES   = 18;
  localparam int CODE_W  = 8;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(COLS);
  localparam int DOT_W   = $clog2(DOTS);
  localparam int FROW_W  = $clog2(LINES);
  localparam int ADDR_W  = ROW_W + COL_W;
  localparam int START_W = 6;

  typedef struct packed {
    logic              cblank;
    logic              blink;
    logic [CODE_W-1:0] code;
  } cell_t;

  localparam int DATA_W = $bits(cell_t);
endpackage

// File: rtl/ovl_cellmap.sv
module ovl_cellmap
  import ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic               wr_is_reg,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ROW_W-1:0]   rd_row,
  input  logic [COL_W-1:0]   rd_col,
  output cell_t              rd_cell,
  output logic [START_W-1:0] hstart,
  output logic [START_W-1:0] vstart,
  output logic [1:0]         hmag,
  output logic [1:0]         vmag,
  output logic               slow_sel
);
  cell_t cells [ROWS][COLS];

  logic [ROW_W-1:0] w_row;
  logic [COL_W-1:0] w_col;
  logic             map_we;
  logic             reg_we;

  assign w_row  = wr_addr[ADDR_W-1:COL_W];
  assign w_col  = wr_addr[COL_W-1:0];
  assign map_we = wr_valid && !wr_is_reg &&
                  (w_row < ROW_W'(ROWS)) && (w_col < COL_W'(COLS));
  assign reg_we = wr_valid && wr_is_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          cells[r][c] <= '0;
    end else if (map_we) begin
      cells[w_row][w_col] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hstart   <= '0;
      vstart   <= '0;
      hmag     <= '0;
      vmag     <= '0;
      slow_sel <= 1'b0;
    end else if (reg_we) begin
      case (wr_addr[1:0])
        2'd0: hstart   <= wr_data[START_W-1:0];
        2'd1: vstart   <= wr_data[START_W-1:0];
        2'd2: begin
          hmag <= wr_data[1:0];
          vmag <= wr_data[3:2];
        end
        default: slow_sel <= wr_data[0];
      endcase
    end
  end

  assign rd_cell = cells[rd_row][rd_col];
endmodule

// File: rtl/ovl_scan.sv
module ovl_scan
  import ovl_pkg::*;
#(
  parameter int H_STEP = 4,
  parameter int V_STEP = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hsync,
  input  logic               vsync,
  input  logic [START_W-1:0] hstart,
  input  logic [START_W-1:0] vstart,
  input  logic [1:0]         hmag,
  input  logic [1:0]         vmag,
  output logic               act,
  output logic [COL_W-1:0]   col,
  output logic [DOT_W-1:0]   dot,
  output logic [ROW_W-1:0]   crow,
  output logic [FROW_W-1:0]  frow
);
  localparam int HW = $clog2((2**START_W - 1) * H_STEP + 2);
  localparam int VW = $clog2((2**START_W - 1) * V_STEP + 2);
  localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(DOTS - 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [FROW_W-1:0] FROW_LAST = FROW_W'(LINES - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);

  logic [HW-1:0] hcnt, x0;
  logic [VW-1:0] lcnt, y0;
  logic [1:0]    hlim, vlim, hsub, vsub;
  logic          h_act, h_done, v_act, v_done;

  assign x0   = HW'(hstart) * HW'(H_STEP);
  assign y0   = VW'(vstart) * VW'(V_STEP);
  assign hlim = (hmag == 2'd3) ? 2'd2 : hmag;
  assign vlim = (vmag == 2'd3) ? 2'd2 : vmag;

  // dot tracker: restarts on every line strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; h_act <= 1'b0; h_done <= 1'b0;
      hsub <= '0; dot <= '0; col <= '0;
    end else if (hsync) begin
      hcnt <= '0; h_act <= 1'b0; h_done <= 1'b0;
    end else begin
      if (hcnt != {HW{1'b1}}) hcnt <= hcnt + 1'b1;
      if (!h_act && !h_done && hcnt == x0) begin
        h_act <= 1'b1; hsub <= '0; dot <= '0; col <= '0;
      end else if (h_act) begin
        if (hsub < hlim) hsub <= hsub + 2'd1;
        else begin
          hsub <= '0;
          if (dot != DOT_LAST) dot <= dot + 1'b1;
          else begin
            dot <= '0;
            if (col != COL_LAST) col <= col + 1'b1;
            else begin
              h_act  <= 1'b0;
              h_done <= 1'b1;
            end
          end
        end
      end
    end
  end

  // line tracker: advances on line strobes, restarts on field strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcnt <= '0; v_act <= 1'b0; v_done <= 1'b0;
      vsub <= '0; frow <= '0; crow <= '0;
    end else if (vsync) begin
      lcnt <= '0; v_act <= 1'b0; v_done <= 1'b0;
    end else if (hsync) begin
      if (lcnt != {VW{1'b1}}) lcnt <= lcnt + 1'b1;
      if (!v_act && !v_done && lcnt == y0) begin
        v_act <= 1'b1; vsub <= '0; frow <= '0; crow <= '0;
      end else if (v_act) begin
        if (vsub < vlim) vsub <= vsub + 2'd1;
        else begin
          vsub <= '0;
          if (frow != FROW_LAST) frow <= frow + 1'b1;
          else begin
            frow <= '0;
            if (crow != ROW_LAST) crow <= crow + 1'b1;
            else begin
              v_act  <= 1'b0;
              v_done <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign act = h_act && v_act;

  assert_col_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    h_act |-> (col <= COL_LAST && dot <= DOT_LAST))
    else $error("column or dot index out of range");

  assert_row_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    v_act |-> (frow <= FROW_LAST && crow <= ROW_LAST))
    else $error("font row or map row out of range");

  assert_line_state_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync && !vsync) |=> $stable(v_act))
    else $error("line activity changed without a sync strobe");

  assert_line_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_done && !hsync) |=> !h_act)
    else $error("dot tracker restarted within a line");
endmodule

// File: rtl/ovl_blink.sv
module ovl_blink #(
  parameter int BLINK_FAST = 15,
  parameter int BLINK_SLOW = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic slow_sel,
  output logic phase_off
);
  localparam int FW = $clog2(BLINK_SLOW + 1);

  logic [FW-1:0] fcnt;
  logic [FW-1:0] lim;

  assign lim = slow_sel ? FW'(BLINK_SLOW - 1) : FW'(BLINK_FAST - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt      <= '0;
      phase_off <= 1'b0;
    end else if (vsync) begin
      if (fcnt >= lim) begin
        fcnt      <= '0;
        phase_off <= !phase_off;
      end else begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(phase_off))
    else $error("blink phase moved between field strobes");

  assert_field_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt < FW'(BLINK_SLOW))
    else $error("field counter beyond slow period");
endmodule

// File: rtl/char_overlay_raster.sv
module char_overlay_raster
  import ovl_pkg::*;
#(
  parameter int H_STEP     = 4,
  parameter int V_STEP     = 2,
  parameter int BLINK_FAST = 15,
  parameter int BLINK_SLOW = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_is_reg,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] font_code,
  output logic [FROW_W-1:0] font_row,
  input  logic [DOTS-1:0]   font_bits,
  output logic              chr_out,
  output logic              blank_out
);
  localparam logic [DOT_W-1:0] DOT_LAST = DOT_W'(DOTS - 1);

  logic [START_W-1:0] hstart, vstart;
  logic [1:0]         hmag, vmag;
  logic               slow_sel, phase_off;
  logic               act_a;
  logic [COL_W-1:0]   col_a;
  logic [DOT_W-1:0]   dot_a;
  logic [ROW_W-1:0]   crow_a;
  logic [FROW_W-1:0]  frow_a;
  cell_t              cell_a;

  assign wr_ready = 1'b1;

  ovl_cellmap u_map (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_is_reg(wr_is_reg),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_row(crow_a), .rd_col(col_a),
    .rd_cell(cell_a), .hstart(hstart), .vstart(vstart), .hmag(hmag),
    .vmag(vmag), .slow_sel(slow_sel)
  );

  ovl_scan #(.H_STEP(H_STEP), .V_STEP(V_STEP)) u_scan (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .hstart(hstart), .vstart(vstart), .hmag(hmag), .vmag(vmag),
    .act(act_a), .col(col_a), .dot(dot_a), .crow(crow_a), .frow(frow_a)
  );

  ovl_blink #(.BLINK_FAST(BLINK_FAST), .BLINK_SLOW(BLINK_SLOW)) u_blink (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .slow_sel(slow_sel),
    .phase_off(phase_off)
  );

  assign font_code = cell_a.code;
  assign font_row  = frow_a;

  // stage B: aligned with the font answer
  logic             act_b, blink_b, cblank_b, lit_b;
  logic [DOT_W-1:0] dot_b;
  // stage C: one dot of look-ahead for the right-hand border
  logic             act_c, lit_c, cblank_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_b <= 1'b0; dot_b <= '0; blink_b <= 1'b0; cblank_b <= 1'b0;
    end else begin
      act_b    <= act_a;
      dot_b    <= dot_a;
      blink_b  <= cell_a.blink;
      cblank_b <= cell_a.cblank;
    end
  end

  assign lit_b = act_b && font_bits[DOT_LAST - dot_b] && !(blink_b && phase_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_c <= 1'b0; lit_c <= 1'b0; cblank_c <= 1'b0;
      chr_out <= 1'b0; blank_out <= 1'b0;
    end else begin
      act_c     <= act_b;
      lit_c     <= lit_b;
      cblank_c  <= act_b && cblank_b;
      chr_out   <= lit_c;
      blank_out <= lit_c || cblank_c || (act_c && (chr_out || lit_b));
    end
  end

  assert_char_keys_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chr_out |-> blank_out)
    else $error("character dot without blank");

  assert_char_in_area_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chr_out |-> $past(act_b, 2))
    else $error("character dot outside the display area");

  assert_cell_blank_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cblank_c |=> blank_out)
    else $error("blanked cell did not key blank");
endmodule

// File: tb/tb_char_overlay_raster.sv
module tb_char_overlay_raster;
  localparam int CLK_PERIOD = 10;
  localparam int H_STEP = 4;
  localparam int V_STEP = 2;
  localparam int FAST = 15;
  localparam int SLOW = 30;

  logic clk, rst_n, hsync, vsync, wr_valid, wr_ready, wr_is_reg;
  logic [8:0]  wr_addr;
  logic [9:0]  wr_data;
  logic [7:0]  font_code;
  logic [4:0]  font_row;
  logic [11:0] font_bits;
  logic chr_out, blank_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [9:0] shadow [12][24];
  int hs, vs, hm, vm, slow, vcount;

  char_overlay_raster dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_is_reg(wr_is_reg),
    .wr_addr(wr_addr), .wr_data(wr_data), .font_code(font_code),
    .font_row(font_row), .font_bits(font_bits), .chr_out(chr_out),
    .blank_out(blank_out)
  );

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [11:0] font_fn(logic [7:0] c, logic [4:0] r);
    return 12'(({4'd0, c} * 12'd37) ^ ({7'd0, r} * 12'd211) ^ {c[3:0], 8'h5A});
  endfunction

  // font store model: answers one clock after the request (R5)
  always_ff @(posedge clk) font_bits <= font_fn(font_code, font_row);

  function automatic int mag_of(int code);
    return (code == 0) ? 1 : (code == 1) ? 2 : 3;
  endfunction

  function automatic bit off_phase();
    int lim = slow ? SLOW : FAST;
    return ((vcount / lim) % 2) == 1;
  endfunction

  function automatic bit valid_fn(int ln, int p);
    int vl = ln - vs * V_STEP;
    return (vl >= 0) && (vl < 216 * vm) && (p >= 0) && (p < 288 * hm);
  endfunction

  function automatic logic [9:0] cell_at(int ln, int p);
    int tr = (ln - vs * V_STEP) / vm;
    int dt = p / hm;
    return shadow[tr / 18][dt / 12];
  endfunction

  function automatic bit lit_fn(int ln, int p);
    logic [9:0] cl;
    logic [11:0] fb;
    int tr, dt;
    if (!valid_fn(ln, p)) return 0;
    tr = (ln - vs * V_STEP) / vm;
    dt = p / hm;
    cl = cell_at(ln, p);
    if (cl[8] && off_phase()) return 0;
    fb = font_fn(cl[7:0], 5'(tr % 18));
    return fb[11 - (dt % 12)];
  endfunction

  task automatic chk(string req, string what, int ln, int p, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s line=%0d dot=%0d actual=%0b expected=%0b", req, what, ln, p, act, exp);
    end
  endtask

  task automatic wr(bit is_reg, logic [8:0] a, logic [9:0] d);
    wr_valid = 1; wr_is_reg = is_reg; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_valid = 0;
    if (is_reg) begin
      case (a[1:0])
        2'd0: hs = int'(d[5:0]);
        2'd1: vs = int'(d[5:0]);
        2'd2: begin hm = mag_of(int'(d[1:0])); vm = mag_of(int'(d[3:2])); end
        default: slow = int'(d[0]);
      endcase
    end else if (a[8:5] < 12 && a[4:0] < 24) begin
      shadow[a[8:5]][a[4:0]] = d;
    end
  endtask

  task automatic do_reset();
    rst_n = 0; hsync = 0; vsync = 0; wr_valid = 0; wr_is_reg = 0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int r = 0; r < 12; r++)
      for (int c = 0; c < 24; c++) shadow[r][c] = '0;
    hs = 0; vs = 0; hm = 1; vm = 1; slow = 0; vcount = 0;
  endtask

  task automatic vsync_pulse();
    vsync = 1; @(posedge clk); @(negedge clk);
    vsync = 0; vcount++;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic fill(int blink_pct, int blank_pct);
    for (int r = 0; r < 12; r++)
      for (int c = 0; c < 24; c++) begin
        logic [9:0] d;
        d[7:0] = 8'($urandom);
        d[8]   = ($urandom % 100) < blink_pct;
        d[9]   = ($urandom % 100) < blank_pct;
        wr(0, {4'(r), 5'(c)}, d);
      end
  endtask

  task automatic run_line(int ln, bit check, string tag);
    int n, p;
    bit ec, eb;
    hsync = 1; @(posedge clk); @(negedge clk);
    hsync = 0;
    if (!check) begin
      @(posedge clk); @(negedge clk);
      return;
    end
    n = hs * H_STEP + 4 + 288 * hm + 2;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); @(negedge clk);
      if (k >= 4) begin
        p  = k - (hs * H_STEP + 4);
        ec = lit_fn(ln, p);
        eb = ec || (valid_fn(ln, p) &&
             (cell_at(ln, p)[9] || lit_fn(ln, p - 1) || lit_fn(ln, p + 1)));
        chk({tag, " R8"}, "chr_out", ln, p, chr_out, ec);
        chk({tag, " R9 R10"}, "blank_out", ln, p, blank_out, eb);
      end
    end
  endtask

  task automatic frame(int l0, int l1, int l2, string tag);
    int total;
    vsync_pulse();
    total = vs * V_STEP + 216 * vm + 1;
    for (int ln = 0; ln < total; ln++)
      run_line(ln, (ln == l0) || (ln == l1) || (ln == l2), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    // R12: reset state at the ports; R2: never back-pressures
    chk("R12", "chr_out after reset", 0, 0, chr_out, 1'b0);
    chk("R12", "blank_out after reset", 0, 0, blank_out, 1'b0);
    chk("R2", "wr_ready", 0, 0, wr_ready, 1'b1);
    // R12: cleared map and zero registers give code 0 at the origin
    frame(0, 17, 18, "R12");

    // R3 R4 R5: offsets at x1, line before the field must be dark
    fill(0, 12);
    wr(1, 9'd0, 10'd5);
    wr(1, 9'd1, 10'd3);
    frame(5, 6, 6 + 18 * 5 + 7, "R3 R4 R5 R2");

    // R6 R7: x2 horizontal, x3 vertical
    wr(1, 9'd0, 10'd0);
    wr(1, 9'd1, 10'd0);
    wr(1, 9'd2, {6'd0, 2'd2, 2'd1});
    frame(0, 3 * 17 + 2, 3 * 18 * 11 + 5, "R6 R7");

    // R1: out-of-range map writes must not alias into any cell
    wr(0, {4'd12, 5'd0}, 10'h3FF);
    wr(0, {4'd0, 5'd24}, 10'h3FF);
    wr(0, {4'd15, 5'd31}, 10'h3FF);
    // R6: size code 3 acts as x3; R3 R4: largest origin
    wr(1, 9'd0, 10'd63);
    wr(1, 9'd1, 10'd63);
    wr(1, 9'd2, {6'd0, 2'd1, 2'd3});
    frame(126, 126 + 36, 126 + 2 * 18 * 11 + 1, "R1 R3 R4 R6");

    // R11: fast blink, on then off phase
    do_reset();
    fill(50, 10);
    wr(1, 9'd0, 10'd2);
    wr(1, 9'd1, 10'd1);
    frame(5, 2 + 40, 2 + 200, "R11 fast-on");
    repeat (13) vsync_pulse();
    frame(5, 2 + 40, 2 + 200, "R11 fast-off");

    // R11: slow blink, last on field and first off field
    do_reset();
    wr(1, 9'd3, 10'd1);
    fill(50, 10);
    repeat (28) vsync_pulse();
    frame(3, 60, 150, "R11 slow-on");
    frame(3, 60, 150, "R11 slow-off R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule